// File: doc/BRIEF.md
# I2C Target with Clock-Stretch Wait

This block is the target side of a two-wire serial bus. It watches an open-drain clock line and data line, recognises start and stop conditions, and compares the first byte of each transfer with a programmable 7-bit own address. When the address is one of its own, it acknowledges on the ninth clock without any help from the host. It then holds the clock line low and raises an interrupt, so the host can respond at its own pace. A transfer addressed to some other target is not acknowledged and is ignored until the next start condition.

After each acknowledged byte the block stretches the clock in the same way. In the write direction it captures each data byte and acknowledges it when the host's acknowledge-enable input is set. In the read direction it shifts out a byte the host has loaded, most significant bit first, and records whether the controller acknowledged it. The wait ends only when the host pulses the release input. Line drive outputs are active-high "pull low" requests meant for open-drain pads. The line inputs pass through a configurable synchroniser before any decision is made.

Top module: `i2c_tgt_stretch`

## Requirements
- R1: After reset both line-drive outputs are 0 (lines released), `irq_o` is 0 and `rx_data_o` is 0.
- R2: When the 7 address bits of the first byte after START (received MSB-first, followed by the direction bit) equal `own_addr_i`, the block pulls SDA low during the 9th clock as an acknowledge.
- R3: After a matched address, SCL is held low from the falling edge of the 9th clock, `irq_o` pulses for one cycle with `irq_xfer_o` = 0 (address match), and `rw_o` shows the direction bit (1 = controller reads).
- R4: On a non-matching address SDA stays released on the 9th clock, no interrupt is raised, SCL is never held, and further bytes get no acknowledge and no interrupt until the next START.
- R5: After a received data byte the block acknowledges on the 9th clock when `ack_en_i` is 1 and leaves SDA released (not acknowledged) when it is 0.
- R6: After every data byte in either direction, SCL is held low from the falling edge of the 9th clock and `irq_o` pulses once with `irq_xfer_o` = 1. For a received byte, `rx_data_o` then holds that byte.
- R7: A held SCL stays low for any length of time until `wait_rel_i` is pulsed high for a cycle. SCL is released right after that pulse.
- R8: When the direction bit is 1, each release of the wait loads `tx_data_i` and sends it MSB-first, and SDA changes only while SCL is low.
- R9: The controller's response on the 9th clock of a sent byte is stored in `mst_nack_o` (1 = not acknowledged). A release after a not-acknowledged byte leaves both lines released until the next START.
- R10: START (SDA falling while SCL is high) restarts address reception, including mid-transfer. STOP (SDA rising while SCL is high) releases both lines and returns the block to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| scl_i | input | 1 | Clock line level seen at the pad |
| sda_i | input | 1 | Data line level seen at the pad |
| scl_low_o | output | 1 | 1 = pull the clock line low (stretch) |
| sda_low_o | output | 1 | 1 = pull the data line low |
| own_addr_i | input | 7 | Programmed own address |
| ack_en_i | input | 1 | Acknowledge received data bytes when 1 |
| tx_data_i | input | 8 | Byte to send, taken at each wait release in read direction |
| wait_rel_i | input | 1 | One-cycle pulse that ends a clock-stretch wait |
| rx_data_o | output | 8 | Last received data byte |
| irq_o | output | 1 | One-cycle pulse when a wait begins |
| irq_xfer_o | output | 1 | Cause of last interrupt: 0 address match, 1 end of byte |
| rw_o | output | 1 | Direction bit of the last matched address |
| mst_nack_o | output | 1 | Controller did not acknowledge the last sent byte |

## Verification
The bench keeps the 8-bit byte width and raises the synchroniser depth to three stages. This checks that the start, stop and edge detection and the acknowledge timing hold up under extra input latency, well inside a 16-cycle half bit. The vector table covers address values at the extremes (all zeros, all ones, a mismatch only in the top bit) combined with both acknowledge-enable settings. Directed runs add an indefinitely held wait, a two-byte read ending in a not-acknowledged byte, and repeated starts that switch between a foreign and an own address.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;

  // Protocol engine phases
  typedef enum logic [2:0] {
    ST_IDLE,    // bus free or not yet addressed
    ST_IGNORE,  // transfer belongs to another target
    ST_ADDR,    // shifting in address and direction
    ST_RX,      // shifting in a data byte
    ST_TX,      // shifting out a data byte
    ST_WAIT     // clock held low until host release
  } tgt_state_e;

endpackage

// File: rtl/i2c_tgt_sync.sv
module i2c_tgt_sync #(
  parameter int STAGES = 2,
  parameter int WIDTH  = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);

  // One flop chain per line; idle bus level is high
  for (genvar g = 0; g < WIDTH; g++) begin : g_line
    logic [STAGES-1:0] pipe_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) pipe_q <= '1;
      else         pipe_q <= {pipe_q[STAGES-2:0], d_i[g]};
    end
    assign q_o[g] = pipe_q[STAGES-1];
  end

endmodule

// File: rtl/i2c_tgt_cond.sv
module i2c_tgt_cond (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_s_i,
  input  logic sda_s_i,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);

  logic scl_prev_q, sda_prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_prev_q <= 1'b1;
      sda_prev_q <= 1'b1;
    end else begin
      scl_prev_q <= scl_s_i;
      sda_prev_q <= sda_s_i;
    end
  end

  logic scl_steady_hi;
  assign scl_steady_hi = scl_s_i & scl_prev_q;

  assign scl_rise_o = scl_s_i & ~scl_prev_q;
  assign scl_fall_o = ~scl_s_i & scl_prev_q;
  assign start_o    = scl_steady_hi & sda_prev_q & ~sda_s_i;
  assign stop_o     = scl_steady_hi & ~sda_prev_q & sda_s_i;

endmodule

// File: rtl/i2c_tgt_fsm.sv
module i2c_tgt_fsm
  import i2c_tgt_pkg::*;
#(
  parameter int DATA_W = 8,
  localparam int ADDR_W = DATA_W - 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scl_s_i,
  input  logic              sda_s_i,
  input  logic              scl_rise_i,
  input  logic              scl_fall_i,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic [ADDR_W-1:0] own_addr_i,
  input  logic              ack_en_i,
  input  logic [DATA_W-1:0] tx_data_i,
  input  logic              wait_rel_i,
  output logic              scl_low_o,
  output logic              sda_low_o,
  output logic [DATA_W-1:0] rx_data_o,
  output logic              irq_o,
  output logic              irq_xfer_o,
  output logic              rw_o,
  output logic              mst_nack_o
);

  localparam int CNT_W = $clog2(DATA_W + 2);
  localparam logic [CNT_W-1:0] C_LAST = CNT_W'(DATA_W);
  localparam logic [CNT_W-1:0] C_ACK  = CNT_W'(DATA_W + 1);
  localparam logic [CNT_W-1:0] C_ONE  = CNT_W'(1);

  tgt_state_e        state_q, state_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [DATA_W-1:0] sh_q, sh_d;
  logic [DATA_W-1:0] rx_q, rx_d;
  logic              rw_q, rw_d;
  logic              nack_q, nack_d;
  logic              scl_low_q, scl_low_d;
  logic              sda_low_q, sda_low_d;
  logic              irq_q, irq_d;
  logic              xfer_q, xfer_d;

  // Next-state logic
  always_comb begin
    state_d   = state_q;
    cnt_d     = cnt_q;
    sh_d      = sh_q;
    rx_d      = rx_q;
    rw_d      = rw_q;
    nack_d    = nack_q;
    scl_low_d = scl_low_q;
    sda_low_d = sda_low_q;
    irq_d     = 1'b0;
    xfer_d    = xfer_q;

    if (stop_i) begin
      state_d   = ST_IDLE;
      cnt_d     = '0;
      scl_low_d = 1'b0;
      sda_low_d = 1'b0;
    end else if (start_i) begin
      state_d   = ST_ADDR;
      cnt_d     = '0;
      scl_low_d = 1'b0;
      sda_low_d = 1'b0;
    end else begin
      unique case (state_q)
        ST_ADDR, ST_RX: begin
          if (scl_rise_i) begin
            if (cnt_q < C_LAST) begin
              sh_d  = {sh_q[DATA_W-2:0], sda_s_i};
              cnt_d = cnt_q + C_ONE;
            end else if (cnt_q == C_LAST) begin
              cnt_d = C_ACK;
            end
          end else if (scl_fall_i) begin
            if (cnt_q == C_LAST) begin
              // end of 8th clock: decide acknowledge
              if (state_q == ST_ADDR) begin
                if (sh_q[DATA_W-1:1] == own_addr_i) begin
                  sda_low_d = 1'b1;
                  rw_d      = sh_q[0];
                  nack_d    = 1'b0;
                end else begin
                  state_d = ST_IGNORE;
                end
              end else begin
                sda_low_d = ack_en_i;
                rx_d      = sh_q;
              end
            end else if (cnt_q == C_ACK) begin
              // end of 9th clock: stretch and notify
              sda_low_d = 1'b0;
              scl_low_d = 1'b1;
              irq_d     = 1'b1;
              xfer_d    = (state_q == ST_RX);
              state_d   = ST_WAIT;
            end
          end
        end
        ST_TX: begin
          if (scl_rise_i) begin
            if (cnt_q == C_LAST) nack_d = sda_s_i;
            if (cnt_q <= C_LAST) cnt_d = cnt_q + C_ONE;
          end else if (scl_fall_i) begin
            if (cnt_q >= C_ONE && cnt_q < C_LAST) begin
              sh_d      = {sh_q[DATA_W-2:0], 1'b0};
              sda_low_d = ~sh_q[DATA_W-2];
            end else if (cnt_q == C_LAST) begin
              sda_low_d = 1'b0;
            end else if (cnt_q == C_ACK) begin
              scl_low_d = 1'b1;
              irq_d     = 1'b1;
              xfer_d    = 1'b1;
              state_d   = ST_WAIT;
            end
          end
        end
        ST_WAIT: begin
          if (wait_rel_i) begin
            scl_low_d = 1'b0;
            cnt_d     = '0;
            if (!rw_q) begin
              state_d = ST_RX;
            end else if (nack_q) begin
              state_d = ST_IGNORE;
            end else begin
              state_d   = ST_TX;
              sh_d      = tx_data_i;
              sda_low_d = ~tx_data_i[DATA_W-1];
            end
          end
        end
        default: ;
      endcase
    end
  end

  // State registers
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      cnt_q     <= '0;
      sh_q      <= '0;
      rx_q      <= '0;
      rw_q      <= 1'b0;
      nack_q    <= 1'b0;
      scl_low_q <= 1'b0;
      sda_low_q <= 1'b0;
      irq_q     <= 1'b0;
      xfer_q    <= 1'b0;
    end else begin
      state_q   <= state_d;
      cnt_q     <= cnt_d;
      sh_q      <= sh_d;
      rx_q      <= rx_d;
      rw_q      <= rw_d;
      nack_q    <= nack_d;
      scl_low_q <= scl_low_d;
      sda_low_q <= sda_low_d;
      irq_q     <= irq_d;
      xfer_q    <= xfer_d;
    end
  end

  assign scl_low_o  = scl_low_q;
  assign sda_low_o  = sda_low_q;
  assign rx_data_o  = rx_q;
  assign irq_o      = irq_q;
  assign irq_xfer_o = xfer_q;
  assign rw_o       = rw_q;
  assign mst_nack_o = nack_q;

  // Acknowledge of an address only for the programmed one
  assert_addr_ack_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sda_low_q && state_q == ST_ADDR) |-> (own_addr_i == sh_q[DATA_W-1:1]));

  // A foreign transfer never stretches, drives or interrupts
  assert_ignore_quiet_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IGNORE) |-> (!scl_low_q && !sda_low_q && !irq_q));

  // Interrupt is a single-cycle pulse
  assert_irq_pulse_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_q |=> !irq_q);

  // Stretch persists until released
  assert_wait_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (scl_low_q && !wait_rel_i && !stop_i && !start_i) |=> scl_low_q);

  // Data line only moves while the clock is low
  assert_sda_scl_low_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(sda_low_q) |-> !$past(scl_s_i));

endmodule

// File: rtl/i2c_tgt_stretch.sv
module i2c_tgt_stretch #(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2,
  localparam int ADDR_W     = DATA_W - 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              scl_low_o,
  output logic              sda_low_o,
  input  logic [ADDR_W-1:0] own_addr_i,
  input  logic              ack_en_i,
  input  logic [DATA_W-1:0] tx_data_i,
  input  logic              wait_rel_i,
  output logic [DATA_W-1:0] rx_data_o,
  output logic              irq_o,
  output logic              irq_xfer_o,
  output logic              rw_o,
  output logic              mst_nack_o
);

  // Reset: asserted asynchronously, removed on a clock edge
  logic [1:0] rst_pipe_q;
  logic       rst_n;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_pipe_q <= 2'b00;
    else         rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_n = rst_pipe_q[1];

  logic [1:0] line_s;
  logic scl_rise, scl_fall, bus_start, bus_stop;

  i2c_tgt_sync #(.STAGES(SYNC_STAGES), .WIDTH(2)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_n),
    .d_i    ({sda_i, scl_i}),
    .q_o    (line_s)
  );

  i2c_tgt_cond u_cond (
    .clk_i      (clk_i),
    .rst_ni     (rst_n),
    .scl_s_i    (line_s[0]),
    .sda_s_i    (line_s[1]),
    .scl_rise_o (scl_rise),
    .scl_fall_o (scl_fall),
    .start_o    (bus_start),
    .stop_o     (bus_stop)
  );

  i2c_tgt_fsm #(.DATA_W(DATA_W)) u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_n),
    .scl_s_i    (line_s[0]),
    .sda_s_i    (line_s[1]),
    .scl_rise_i (scl_rise),
    .scl_fall_i (scl_fall),
    .start_i    (bus_start),
    .stop_i     (bus_stop),
    .own_addr_i (own_addr_i),
    .ack_en_i   (ack_en_i),
    .tx_data_i  (tx_data_i),
    .wait_rel_i (wait_rel_i),
    .scl_low_o  (scl_low_o),
    .sda_low_o  (sda_low_o),
    .rx_data_o  (rx_data_o),
    .irq_o      (irq_o),
    .irq_xfer_o (irq_xfer_o),
    .rw_o       (rw_o),
    .mst_nack_o (mst_nack_o)
  );

endmodule

// File: tb/i2c_tgt_stretch_tb.sv
module i2c_tgt_stretch_tb_top;

  localparam int H = 16;  // half bit in clock cycles

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;  // 125 MHz

  logic       m_scl_low = 1'b0, m_sda_low = 1'b0;
  logic       scl_low_o, sda_low_o;
  logic [6:0] own_addr = 7'h00;
  logic       ack_en = 1'b1;
  logic [7:0] tx_data = 8'h00;
  logic       wait_rel = 1'b0;
  logic [7:0] rx_data_o;
  logic       irq_o, irq_xfer_o, rw_o, mst_nack_o;
  logic       bus_scl, bus_sda;

  assign bus_scl = ~(m_scl_low | scl_low_o);
  assign bus_sda = ~(m_sda_low | sda_low_o);

  i2c_tgt_stretch #(.DATA_W(8), .SYNC_STAGES(3)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(bus_scl), .sda_i(bus_sda),
    .scl_low_o(scl_low_o), .sda_low_o(sda_low_o), .own_addr_i(own_addr),
    .ack_en_i(ack_en), .tx_data_i(tx_data), .wait_rel_i(wait_rel),
    .rx_data_o(rx_data_o), .irq_o(irq_o), .irq_xfer_o(irq_xfer_o),
    .rw_o(rw_o), .mst_nack_o(mst_nack_o)
  );

  int checks = 0, failures = 0, irq_cnt = 0;
  bit done = 1'b0;

  always @(negedge clk) if (rst_n && irq_o) irq_cnt++;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wait_h(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic scl_up();
    m_scl_low = 1'b0;
    while (!bus_scl) @(negedge clk);
  endtask

  task automatic m_start();
    m_sda_low = 1'b0; wait_h(H);
    scl_up(); wait_h(H);
    m_sda_low = 1'b1; wait_h(H);
    m_scl_low = 1'b1; wait_h(H);
  endtask

  task automatic m_stop();
    m_sda_low = 1'b1; wait_h(H);
    scl_up(); wait_h(H);
    m_sda_low = 1'b0; wait_h(H);
  endtask

  task automatic m_bit(input logic b, output logic r);
    m_sda_low = ~b; wait_h(H);
    scl_up(); wait_h(H/2);
    r = bus_sda; wait_h(H/2);
    m_scl_low = 1'b1; wait_h(H);
  endtask

  task automatic m_wbyte(input logic [7:0] d, output logic ack);
    logic r;
    for (int i = 7; i >= 0; i--) m_bit(d[i], r);
    m_bit(1'b1, r);
    ack = ~r;
  endtask

  task automatic m_rbyte(input logic give_ack, output logic [7:0] d);
    logic r;
    d = '0;
    for (int i = 0; i < 8; i++) begin
      m_bit(1'b1, r);
      d = {d[6:0], r};
    end
    m_bit(~give_ack, r);
  endtask

  task automatic host_release();
    @(negedge clk) wait_rel = 1'b1;
    @(negedge clk) wait_rel = 1'b0;
    @(negedge clk);
  endtask

  // {own, sent address, data, ack_en, expect address ack, expect data ack}
  localparam logic [24:0] VEC [6] = '{
    {7'h2A, 7'h2A, 8'hA5, 3'b111},
    {7'h2A, 7'h2B, 8'h5A, 3'b100},
    {7'h7F, 7'h7F, 8'h00, 3'b010},
    {7'h00, 7'h00, 8'hFF, 3'b111},
    {7'h55, 7'h54, 8'h3C, 3'b100},
    {7'h01, 7'h41, 8'h81, 3'b100}
  };

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog R7 run did not complete");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic ack;
    logic [7:0] rd;
    int irq0;
    wait_h(5);
    rst_n = 1'b1;
    wait_h(10);

    // R1 reset state
    chk(scl_low_o == 1'b0, "R1 scl released", scl_low_o, 0);
    chk(sda_low_o == 1'b0, "R1 sda released", sda_low_o, 0);
    chk(irq_o == 1'b0 && irq_cnt == 0, "R1 no irq", irq_cnt, 0);
    chk(rx_data_o == 8'h00, "R1 rx clear", rx_data_o, 0);

    // Vector walk: R2 R3 R4 R5 R6 R7
    for (int v = 0; v < 6; v++) begin
      logic [24:0] t;
      t = VEC[v];
      own_addr = t[24:18];
      ack_en   = t[2];
      irq0     = irq_cnt;
      m_start();
      m_wbyte({t[17:11], 1'b0}, ack);
      chk(ack == t[1], "R2/R4 address ack", ack, t[1]);
      if (t[1]) begin
        chk(scl_low_o == 1'b1, "R3 stretch after address", scl_low_o, 1);
        chk(irq_cnt == irq0 + 1 && irq_xfer_o == 1'b0, "R3 address irq", irq_cnt - irq0, 1);
        chk(rw_o == 1'b0, "R3 direction bit", rw_o, 0);
        host_release();
        chk(scl_low_o == 1'b0, "R7 released", scl_low_o, 0);
      end else begin
        chk(scl_low_o == 1'b0 && irq_cnt == irq0, "R4 no wait no irq", irq_cnt - irq0, 0);
      end
      m_wbyte(t[10:3], ack);
      chk(ack == t[0], "R5 data ack per enable", ack, t[0]);
      if (t[1]) begin
        chk(scl_low_o == 1'b1, "R6 stretch after data", scl_low_o, 1);
        chk(irq_cnt == irq0 + 2 && irq_xfer_o == 1'b1, "R6 transfer irq", irq_cnt - irq0, 2);
        chk(rx_data_o == t[10:3], "R6 received byte", rx_data_o, t[10:3]);
        host_release();
      end else begin
        chk(irq_cnt == irq0 && scl_low_o == 1'b0, "R4 data ignored", irq_cnt - irq0, 0);
      end
      m_stop();
      chk(scl_low_o == 1'b0 && sda_low_o == 1'b0, "R10 idle after stop",
          {scl_low_o, sda_low_o}, 0);
    end

    // R7 wait held for a long time
    own_addr = 7'h19; ack_en = 1'b1;
    m_start();
    m_wbyte({7'h19, 1'b0}, ack);
    wait_h(300);
    chk(scl_low_o == 1'b1 && bus_scl == 1'b0, "R7 held without release", scl_low_o, 1);
    host_release();
    chk(scl_low_o == 1'b0, "R7 release ends wait", scl_low_o, 0);
    m_stop();

    // R8 R9 read direction
    own_addr = 7'h33;
    irq0 = irq_cnt;
    m_start();
    m_wbyte({7'h33, 1'b1}, ack);
    chk(ack == 1'b1, "R2 read address ack", ack, 1);
    chk(rw_o == 1'b1 && scl_low_o == 1'b1, "R3 read direction wait", rw_o, 1);
    tx_data = 8'hC6;
    host_release();
    m_rbyte(1'b1, rd);
    chk(rd == 8'hC6, "R8 first byte MSB first", rd, 8'hC6);
    chk(mst_nack_o == 1'b0, "R9 controller ack seen", mst_nack_o, 0);
    chk(scl_low_o == 1'b1 && irq_xfer_o == 1'b1 && irq_cnt == irq0 + 2,
        "R6 wait after sent byte", irq_cnt - irq0, 2);
    tx_data = 8'h3B;
    host_release();
    m_rbyte(1'b0, rd);
    chk(rd == 8'h3B, "R8 second byte", rd, 8'h3B);
    chk(mst_nack_o == 1'b1, "R9 controller nack seen", mst_nack_o, 1);
    host_release();
    chk(scl_low_o == 1'b0 && sda_low_o == 1'b0, "R9 lines free after nack",
        {scl_low_o, sda_low_o}, 0);
    m_stop();

    // R10 repeated start
    own_addr = 7'h12;
    m_start();
    m_wbyte({7'h12, 1'b0}, ack);
    host_release();
    m_wbyte(8'h77, ack);
    chk(rx_data_o == 8'h77, "R6 byte before restart", rx_data_o, 8'h77);
    host_release();
    m_start();
    irq0 = irq_cnt;
    m_wbyte({7'h13, 1'b0}, ack);
    chk(ack == 1'b0, "R10 restart to foreign address", ack, 0);
    m_wbyte(8'h11, ack);
    chk(ack == 1'b0 && irq_cnt == irq0, "R4 ignored until start", irq_cnt - irq0, 0);
    m_start();
    m_wbyte({7'h12, 1'b0}, ack);
    chk(ack == 1'b1 && irq_cnt == irq0 + 1, "R10 restart to own address", ack, 1);
    host_release();
    m_stop();
    chk(scl_low_o == 1'b0 && sda_low_o == 1'b0, "R10 stop releases",
        {scl_low_o, sda_low_o}, 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule